// File: doc/BRIEF.md
# Snapshot Sensor Frame Timing Generator

This block sits on the camera side of an integrate-then-read focal plane readout chip. From the master clock it generates the frame strobe (`fsync`) and the row strobe (`lsync`) that the readout chip needs. Each frame runs three phases in a fixed order. First comes a readout burst with one line strobe per row of the active window. A short reset interval follows. Last comes a programmable integration interval. Because integration starts only when the frame strobe falls, the frame period is the sum of those three phases and not a fixed raster period.

The window size (rows, columns) and the integration length are sampled when a frame starts, so software or a neighbouring controller can change them at any time. The readout chip delivers two pixels per clock, one on each clock edge. A row of N columns on one output therefore occupies ceil(N/2) clocks after its line strobe. The line strobe is launched from the falling clock edge, which puts its rising edge half a period after a rising clock edge. A one-clock `frame_done` pulse marks the end of integration. Three phase flags expose the current phase.

Top module: `snap_frame_timer`

## Requirements
- R1: While `rst` is high, and afterwards for as long as `en` stays low, `fsync`, `lsync`, `frame_done`, `ph_read`, `ph_reset` and `ph_integ` are all 0.
- R2: A frame starts with `fsync` rising. `fsync` then stays high for exactly LEAD_CYC + rows*(1+half) + RESET_CYC clocks, where half = ceil(cols/2). This covers the lead-in, every row and the reset interval.
- R3: The first `lsync` pulse of a frame is high in the clock that is exactly LEAD_CYC clocks after the first clock in which `fsync` is high (LEAD_CYC ≥ 1).
- R4: Each frame gives exactly `rows` `lsync` pulses. Each pulse is one clock wide and rises at a falling clock edge, not at a rising one. Successive pulses start 1+half clocks apart.
- R5: Once `fsync` falls it stays low for exactly the latched integration count. `frame_done` is high for one clock, in the last of those low clocks and in no other clock. If `en` is high at that moment, `fsync` rises in the very next clock.
- R6: A zero value is replaced when it is latched: an integration count of 0 acts as 1, a row count of 0 acts as 1, and a column count of 0 acts as 1 data clock per row.
- R7: The integration count, row count and column count are sampled only in the clock in which a frame starts. Changes made during a frame take effect in the next frame.
- R8: If `en` goes low during a frame, that frame still completes, including its `frame_done`. After that `fsync` and `lsync` stay low until `en` returns high.
- R9: At most one phase flag is high in any clock. Per frame, `ph_read` is high for LEAD_CYC + rows*(1+half) clocks, `ph_reset` for RESET_CYC clocks, and `ph_integ` for the integration count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; frames repeat back to back while high |
| int_cycles | input | INT_W | Integration length in clocks (0 acts as 1) |
| win_rows | input | ROW_W | Rows in the active window (0 acts as 1) |
| win_cols | input | COL_W | Columns in the active window |
| fsync | output | 1 | Frame strobe: high during readout and reset, low during integration |
| lsync | output | 1 | Row strobe, one clock wide, launched on the falling clock edge |
| frame_done | output | 1 | One-clock pulse in the last integration clock |
| ph_read | output | 1 | Lead-in and row readout phase |
| ph_reset | output | 1 | Reset interval phase |
| ph_integ | output | 1 | Integration phase |

## Verification
The bench aims at the boundaries where a timing generator usually goes wrong. It drives odd column counts, where a truncating halving would shorten every row by one clock. It drives zero counts, where a missing clamp would produce a stuck or very long phase. It rewrites the configuration right after each frame starts, which shows up any design that reads live inputs instead of latched ones as a wrong integration or row length. It also looks at where the strobe edge falls inside the clock, and whether one more frame is started after enable is dropped or a frame is cut short instead.

// File: rtl/snap_tim_pkg.sv
package snap_tim_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_LINE,
        PH_RESET,
        PH_INTEG
    } phase_e;

    typedef struct packed {
        logic read;
        logic rst;
        logic integ;
    } phase_flags_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic phase_flags_t flags_of(input phase_e ph);
        phase_flags_t f;
        f.read  = (ph == PH_LEAD) || (ph == PH_LINE);
        f.rst   = (ph == PH_RESET);
        f.integ = (ph == PH_INTEG);
        return f;
    endfunction

endpackage

// File: rtl/sft_cfg_latch.sv
module sft_cfg_latch #(
    parameter int ROW_W = 10,
    parameter int COL_W = 11,
    parameter int INT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] rows_in,
    input  logic [COL_W-1:0] cols_in,
    input  logic [INT_W-1:0] int_in,
    output logic [ROW_W-1:0] rows_q,
    output logic [COL_W-1:0] half_q,
    output logic [INT_W-1:0] int_q
);

    logic [COL_W-1:0] half_raw;

    // two pixels per clock: round an odd column count up
    assign half_raw = COL_W'(cols_in[COL_W-1:1]) + COL_W'(cols_in[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            rows_q <= ROW_W'(1);
            half_q <= COL_W'(1);
            int_q  <= INT_W'(1);
        end else if (load) begin
            rows_q <= (rows_in == '0)  ? ROW_W'(1) : rows_in;
            half_q <= (half_raw == '0) ? COL_W'(1) : half_raw;
            int_q  <= (int_in == '0)   ? INT_W'(1) : int_in;
        end
    end

    AST_CFG_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (rows_q != '0) && (half_q != '0) && (int_q != '0)); // R6

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(int_q) && $stable(rows_q) && $stable(half_q))); // R7

endmodule

// File: rtl/sft_phase_fsm.sv
module sft_phase_fsm
    import snap_tim_pkg::*;
#(
    parameter int ROW_W      = 10,
    parameter int COL_W      = 11,
    parameter int INT_W      = 24,
    parameter int LEAD_CYC   = 2,
    parameter int RESET_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ROW_W-1:0] rows_q,
    input  logic [COL_W-1:0] half_q,
    input  logic [INT_W-1:0] int_q,
    output logic             load,
    output phase_e           phase,
    output logic             lsync_req,
    output logic             frame_done
);

    localparam int CNT_W = max_of(max_of(INT_W, COL_W + 1),
                                  max_of($clog2(LEAD_CYC + 1), $clog2(RESET_CYC + 1)));

    phase_e           state;
    logic [CNT_W-1:0] cnt;
    logic [ROW_W-1:0] row;

    logic lead_last, line_last, row_last, reset_last, integ_last;

    assign lead_last  = (cnt == CNT_W'(LEAD_CYC - 1));
    assign line_last  = (cnt == CNT_W'(half_q));
    assign row_last   = (row == rows_q - ROW_W'(1));
    assign reset_last = (cnt == CNT_W'(RESET_CYC - 1));
    assign integ_last = (cnt == CNT_W'(int_q) - CNT_W'(1));

    assign load       = en && ((state == PH_IDLE) || ((state == PH_INTEG) && integ_last));
    assign lsync_req  = (state == PH_LINE) && (cnt == '0);
    assign frame_done = (state == PH_INTEG) && integ_last;
    assign phase      = state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            cnt   <= '0;
            row   <= '0;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    if (en) begin
                        state <= PH_LEAD;
                        cnt   <= '0;
                    end
                end
                PH_LEAD: begin
                    if (lead_last) begin
                        state <= PH_LINE;
                        cnt   <= '0;
                        row   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_LINE: begin
                    if (line_last) begin
                        cnt <= '0;
                        if (row_last) begin
                            state <= PH_RESET;
                        end else begin
                            row <= row + ROW_W'(1);
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_RESET: begin
                    if (reset_last) begin
                        state <= PH_INTEG;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_INTEG: begin
                    if (integ_last) begin
                        state <= en ? PH_LEAD : PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    state <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == PH_IDLE && !en) |=> (state == PH_IDLE)); // R8

    AST_DONE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (frame_done && en) |=> (state == PH_LEAD)); // R5

    AST_DONE_STOP: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !en) |=> (state == PH_IDLE)); // R8

    AST_READ_TO_RESET: assert property (@(posedge clk) disable iff (rst)
        (state == PH_RESET) |-> ($past(state) == PH_LINE || $past(state) == PH_RESET)); // R2

endmodule

// File: rtl/sft_edge_align.sv
module sft_edge_align #(
    parameter bit FALL_EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    generate
        if (FALL_EDGE) begin : g_fall
            always_ff @(negedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= d;
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= d;
            end
        end
    endgenerate

endmodule

// File: rtl/snap_frame_timer.sv
module snap_frame_timer
    import snap_tim_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 11,
    parameter int INT_W     = 24,
    parameter int LEAD_CYC  = 2,
    parameter int RESET_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [INT_W-1:0] int_cycles,
    input  logic [ROW_W-1:0] win_rows,
    input  logic [COL_W-1:0] win_cols,
    output logic             fsync,
    output logic             lsync,
    output logic             frame_done,
    output logic             ph_read,
    output logic             ph_reset,
    output logic             ph_integ
);

    logic             load;
    logic             lsync_req;
    phase_e           phase;
    phase_flags_t     flags;
    logic [ROW_W-1:0] rows_q;
    logic [COL_W-1:0] half_q;
    logic [INT_W-1:0] int_q;

    sft_cfg_latch #(
        .ROW_W(ROW_W), .COL_W(COL_W), .INT_W(INT_W)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .rows_in(win_rows),
        .cols_in(win_cols),
        .int_in (int_cycles),
        .rows_q (rows_q),
        .half_q (half_q),
        .int_q  (int_q)
    );

    sft_phase_fsm #(
        .ROW_W(ROW_W), .COL_W(COL_W), .INT_W(INT_W),
        .LEAD_CYC(LEAD_CYC), .RESET_CYC(RESET_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .rows_q    (rows_q),
        .half_q    (half_q),
        .int_q     (int_q),
        .load      (load),
        .phase     (phase),
        .lsync_req (lsync_req),
        .frame_done(frame_done)
    );

    sft_edge_align #(.FALL_EDGE(1'b1)) u_align (
        .clk(clk),
        .rst(rst),
        .d  (lsync_req),
        .q  (lsync)
    );

    assign flags    = flags_of(phase);
    assign ph_read  = flags.read;
    assign ph_reset = flags.rst;
    assign ph_integ = flags.integ;
    assign fsync    = flags.read | flags.rst;

    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ph_read, ph_reset, ph_integ})); // R9

    AST_LSYNC_IN_FSYNC: assert property (@(posedge clk) disable iff (rst)
        lsync |-> fsync); // R4

    AST_LSYNC_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        lsync |=> !lsync); // R4

    AST_DONE_IN_LOW: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (ph_integ && !fsync)); // R5

    AST_FALL_INTEG: assert property (@(posedge clk) disable iff (rst)
        $fell(fsync) |-> ph_integ); // R5

endmodule

// File: tb/sim_snap_frame_timer.sv
module sim_snap_frame_timer;

    localparam int ROW_W = 10, COL_W = 11, INT_W = 24;
    localparam int LEAD = 2, RSTC = 4;

    typedef struct {
        int high;
        int first;
        int npulse;
        int period;
        int rd;
        int low;
    } frame_exp_t;

    logic clk = 0, rst = 1, en = 0;
    logic [INT_W-1:0] int_cycles = '0;
    logic [ROW_W-1:0] win_rows = '0;
    logic [COL_W-1:0] win_cols = '0;
    logic fsync, lsync, frame_done, ph_read, ph_reset, ph_integ;

    always #10 clk = ~clk;

    snap_frame_timer #(.ROW_W(ROW_W), .COL_W(COL_W), .INT_W(INT_W),
                       .LEAD_CYC(LEAD), .RESET_CYC(RSTC)) u0 (
        .clk(clk), .rst(rst), .en(en), .int_cycles(int_cycles),
        .win_rows(win_rows), .win_cols(win_cols), .fsync(fsync), .lsync(lsync),
        .frame_done(frame_done), .ph_read(ph_read), .ph_reset(ph_reset),
        .ph_integ(ph_integ));

    int n_chk = 0, n_fail = 0, frames_seen = 0;
    bit finished = 0;
    frame_exp_t expq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // driver: applies a configuration and pushes its expected frame shape
    task automatic push_cfg(input int r, input int c, input int it);
        frame_exp_t e;
        int rr, hh, ii;
        rr = (r == 0) ? 1 : r;
        hh = (c + 1) / 2;
        if (hh == 0) hh = 1;
        ii = (it == 0) ? 1 : it;
        win_rows = ROW_W'(r);
        win_cols = COL_W'(c);
        int_cycles = INT_W'(it);
        e.high = LEAD + rr * (1 + hh) + RSTC;
        e.first = LEAD;
        e.npulse = rr;
        e.period = 1 + hh;
        e.rd = LEAD + rr * (1 + hh);
        e.low = ii;
        expq.push_back(e);
    endtask

    // monitor
    initial begin
        bit pf = 0, pl = 0, in_hi = 0, in_lo = 0, want_rise = 0, early;
        int idx = 0, pulses = 0, first = -1, lastpos = 0, lowc = 0;
        int rdc = 0, rsc = 0, inc = 0;
        bit edge_checked = 0;
        frame_exp_t cur;
        forever begin
            @(posedge clk);
            #5 early = lsync;
            #10;
            if (rst) begin
                pf = 0; pl = 0;
                continue;
            end
            if (want_rise) begin
                chk(fsync, "R5", "fsync rise right after frame_done", fsync, 1);
                want_rise = 0;
            end
            if (fsync && !pf) begin
                if (expq.size() == 0) begin
                    chk(0, "R8", "unexpected frame start", 1, 0);
                    cur = '{0, 0, 0, 0, 0, 0};
                end else begin
                    cur = expq.pop_front();
                end
                in_hi = 1; in_lo = 0; idx = 0; pulses = 0; first = -1;
                rdc = 0; rsc = 0; inc = 0; edge_checked = 0;
            end
            if (in_hi && fsync) begin
                if (lsync && !pl) begin
                    pulses++;
                    if (first < 0) first = idx;
                    else chk(idx - lastpos == cur.period, "R4", "lsync spacing",
                             idx - lastpos, cur.period);
                    lastpos = idx;
                    if (!edge_checked) begin
                        chk(!early, "R4", "lsync rises at falling edge", early, 0);
                        edge_checked = 1;
                    end
                end
                if (lsync && pl) chk(0, "R4", "lsync wider than one clock", 2, 1);
                idx++;
            end
            if (!fsync && lsync) chk(0, "R4", "lsync outside fsync", 1, 0);
            if (in_hi || in_lo) begin
                if (ph_read)  rdc++;
                if (ph_reset) rsc++;
                if (ph_integ) inc++;
                if (int'(ph_read) + int'(ph_reset) + int'(ph_integ) > 1)
                    chk(0, "R9", "more than one phase flag", 2, 1);
            end
            if (!fsync && pf && in_hi) begin
                in_hi = 0; in_lo = 1; lowc = 0;
                chk(idx == cur.high, "R2", "fsync high length", idx, cur.high);
                chk(first == cur.first, "R3", "first lsync offset", first, cur.first);
                chk(pulses == cur.npulse, "R4", "lsync count", pulses, cur.npulse);
            end
            if (in_lo && !fsync) lowc++;
            if (frame_done) begin
                if (!in_lo) begin
                    chk(0, "R5", "stray frame_done", 1, 0);
                end else begin
                    chk(lowc == cur.low, "R5 R7", "integration length", lowc, cur.low);
                    chk(rdc == cur.rd, "R9", "ph_read clocks", rdc, cur.rd);
                    chk(rsc == RSTC, "R9", "ph_reset clocks", rsc, RSTC);
                    chk(inc == cur.low, "R9", "ph_integ clocks", inc, cur.low);
                    in_lo = 0;
                    frames_seen++;
                    want_rise = (expq.size() > 0) && en;
                end
            end
            pf = fsync;
            pl = lsync;
        end
    end

    // stimulus
    initial begin
        int rows_a[4] = '{2, 0, 4, 1};
        int cols_a[4] = '{7, 0, 2, 640};
        int int_a[4]  = '{0, 3, 10, 2};
        win_rows = ROW_W'(3); win_cols = COL_W'(8); int_cycles = INT_W'(5);
        repeat (4) @(posedge clk);
        #15;
        chk({fsync, lsync, frame_done, ph_read, ph_reset, ph_integ} == 6'b0, "R1",
            "outputs during reset", {fsync, lsync, frame_done, ph_read, ph_reset, ph_integ}, 0);
        @(posedge clk); #2 rst = 0;
        repeat (5) begin
            @(posedge clk); #15;
            chk(!fsync && !lsync && !ph_read, "R1", "idle with en low", fsync, 0);
        end
        push_cfg(3, 8, 5);
        en = 1;
        // R7: next configuration written right after each frame start
        for (int k = 0; k < 4; k++) begin
            @(posedge fsync); #1;
            push_cfg(rows_a[k], cols_a[k], int_a[k]);
        end
        @(posedge fsync); #1 en = 0;
        wait (frames_seen == 5);
        repeat (60) begin
            @(posedge clk); #15;
            chk(!fsync && !lsync && !ph_integ, "R8", "held idle after en low", fsync, 0);
        end
        push_cfg(2, 5, 1); // R6 odd cols, R5 minimum integration
        en = 1;
        @(posedge fsync); #1 en = 0;
        wait (frames_seen == 6);
        repeat (10) @(posedge clk);
        #15 chk(expq.size() == 0, "R8", "expected frames left", expq.size(), 0);
        finish_run();
    end

    initial begin
        #(20 * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule